// File: doc/BRIEF.md
# Floating-Point Status and Exception Control

This block holds the floating-point status and control word for a processor's floating-point unit, along with the logic that updates it. Software loads the word through a write port. Bits outside the implemented fields are cleared as the word is stored. The block derives two settings from the stored word: a rounding-direction control and a denormal flush control. Both go to the arithmetic datapath.

When an operation completes, the datapath strobes `op_done_i` and presents five raw exception indications: inexact, underflow, overflow, divide-by-zero and invalid. The block handles them in three steps:

- It rebuilds the flag field from the five indications.
- It merges the new flags into the accumulated cause field.
- It checks the accumulated causes against the enable field. If any enabled cause is set, it raises a one-cycle exception request carrying a fixed code.

A comparison takes part in this update only when its result is unordered. An ordered comparison leaves the word alone.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset, `csr_o` reads 0 and `exc_req_o` is 0.
- R2: A write stores `wr_data_i` masked to bits 18:0. Bits 31:19 of `csr_o` always read 0. The new value is visible on the cycle after the write.
- R3: `rnd_zero_o` is 1 exactly when bits 1:0 hold 2'b01 (round toward zero). The encodings 00, 10 and 11 give 0 (round to nearest even).
- R4: `flush_o` follows bit 18 of the stored word.
- R5: An accepted operation replaces the flag field, bits 6:2, with `op_flags_i`. Bit 0 of `op_flags_i` (inexact) goes to bit 2, and so on up to bit 4 (invalid), which goes to bit 6. The flag field is cleared when `op_flags_i` is zero. The rounding bits, the enable field (bits 11:7) and bit 18 are unchanged.
- R6: When `op_flags_i` is nonzero, an accepted operation ORs it into cause bits 16:12 at the same bit order. Cause bits are never cleared by an operation. Cause bit 17 is changed only by a write.
- R7: An accepted operation with nonzero `op_flags_i` raises `exc_req_o` for one cycle, on the cycle after `op_done_i`, when the updated cause bits 16:12 ANDed with enable bits 11:7 are nonzero. While `exc_req_o` is high, `exc_code_o` is 12'h120; otherwise it is 0.
- R8: With `op_cmp_i` = 1, the operation is accepted only when `cmp_unord_i` = 1. An ordered comparison leaves `csr_o` unchanged and raises no request, whatever `op_flags_i` holds.
- R9: When `wr_en_i` and `op_done_i` are high in the same cycle, the write is stored and the operation is dropped: no flag or cause update and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Write data |
| op_done_i | input | 1 | Operation-complete strobe from the datapath |
| op_cmp_i | input | 1 | Completed operation is a comparison |
| cmp_unord_i | input | 1 | Comparison result was unordered |
| op_flags_i | input | 5 | Raw indications: bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid |
| csr_o | output | 32 | Stored status and control word |
| rnd_zero_o | output | 1 | 1 = round toward zero, 0 = round to nearest even |
| flush_o | output | 1 | Flush denormals to zero |
| exc_req_o | output | 1 | Exception request pulse |
| exc_code_o | output | 12 | Exception code, valid with the request |

## Verification
The assertions assume that `op_cmp_i`, `cmp_unord_i` and `op_flags_i` are only meaningful while `op_done_i` is high. They make no assumption about these inputs otherwise. They also assume that every input is known after reset. The bench drives every input to a defined value at all times, including garbage flags on ordered comparisons and in idle cycles. It sweeps all 32 indication patterns under several enable masks, so that causes accumulate and requests repeat as the requirements predict.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;
  localparam int CSR_W     = 32;
  localparam int RM_LSB    = 0;
  localparam int RM_W      = 2;
  localparam int EXC_N     = 5;
  localparam int FLAG_LSB  = RM_LSB + RM_W;
  localparam int EN_LSB    = FLAG_LSB + EXC_N;
  localparam int CAUSE_LSB = EN_LSB + EXC_N;
  localparam int CAUSE_W   = EXC_N + 1;
  localparam int DN_BIT    = CAUSE_LSB + CAUSE_W;
  localparam int IMPL_W    = DN_BIT + 1;
  localparam int CODE_W    = 12;

  localparam logic [RM_W-1:0]   RM_TO_ZERO = 2'b01;
  localparam logic [CODE_W-1:0] EXC_CODE   = 12'h120;
  localparam logic [CSR_W-1:0]  CSR_MASK   = CSR_W'((64'd1 << IMPL_W) - 64'd1);

  typedef enum logic {
    RND_NEAREST_EVEN = 1'b0,
    RND_TO_ZERO      = 1'b1
  } rnd_e;
endpackage

// File: rtl/fp_status_decode.sv
module fp_status_decode
  import fp_status_pkg::*;
(
  input  logic [RM_W-1:0] rm_i,
  input  logic            dn_i,
  output rnd_e            rnd_o,
  output logic            flush_o
);
  always_comb begin
    rnd_o   = (rm_i == RM_TO_ZERO) ? RND_TO_ZERO : RND_NEAREST_EVEN;
    flush_o = dn_i;
  end
endmodule

// File: rtl/fp_status_update.sv
module fp_status_update
  import fp_status_pkg::*;
(
  input  logic [CSR_W-1:0] csr_i,
  input  logic [EXC_N-1:0] flags_i,
  output logic [CSR_W-1:0] csr_o,
  output logic             trap_o
);
  logic             any_flag;
  logic [CAUSE_W-1:0] cause_old, cause_new;
  logic [EXC_N-1:0] enables;

  assign any_flag  = |flags_i;
  assign cause_old = csr_i[CAUSE_LSB +: CAUSE_W];
  assign enables   = csr_i[EN_LSB +: EXC_N];

  // Causes covered by a datapath indication accumulate; the extra top cause bit is write-only.
  for (genvar g = 0; g < CAUSE_W; g++) begin : g_cause
    if (g < EXC_N) begin : g_acc
      assign cause_new[g] = cause_old[g] | (any_flag & flags_i[g]);
    end else begin : g_keep
      assign cause_new[g] = cause_old[g];
    end
  end

  always_comb begin
    csr_o = csr_i;
    csr_o[FLAG_LSB +: EXC_N]    = flags_i;
    csr_o[CAUSE_LSB +: CAUSE_W] = cause_new;
    trap_o = any_flag && (|(cause_new[EXC_N-1:0] & enables));
  end
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fp_status_pkg::*;
#(
  parameter logic [CSR_W-1:0] RESET_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CSR_W-1:0]  wr_data_i,
  input  logic              op_done_i,
  input  logic              op_cmp_i,
  input  logic              cmp_unord_i,
  input  logic [EXC_N-1:0]  op_flags_i,
  output logic [CSR_W-1:0]  csr_o,
  output logic              rnd_zero_o,
  output logic              flush_o,
  output logic              exc_req_o,
  output logic [CODE_W-1:0] exc_code_o
);
  logic [CSR_W-1:0] csr_q, csr_upd;
  logic             trap, take, req_q;
  rnd_e             rnd;

  // Write wins; an ordered compare does not touch status.
  assign take = op_done_i && !wr_en_i && (!op_cmp_i || cmp_unord_i);

  fp_status_update u_update (
    .csr_i   (csr_q),
    .flags_i (op_flags_i),
    .csr_o   (csr_upd),
    .trap_o  (trap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q <= RESET_VAL & CSR_MASK;
      req_q <= 1'b0;
    end else begin
      req_q <= take && trap;
      if (wr_en_i)   csr_q <= wr_data_i & CSR_MASK;
      else if (take) csr_q <= csr_upd;
    end
  end

  fp_status_decode u_decode (
    .rm_i    (csr_q[RM_LSB +: RM_W]),
    .dn_i    (csr_q[DN_BIT]),
    .rnd_o   (rnd),
    .flush_o (flush_o)
  );

  assign csr_o      = csr_q;
  assign rnd_zero_o = (rnd == RND_TO_ZERO);
  assign exc_req_o  = req_q;
  assign exc_code_o = req_q ? EXC_CODE : '0;
endmodule

// File: rtl/fp_status_ctrl_chk.sv
module fp_status_ctrl_chk
  import fp_status_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [CSR_W-1:0]  wr_data_i,
  input logic              op_done_i,
  input logic              op_cmp_i,
  input logic              cmp_unord_i,
  input logic [EXC_N-1:0]  op_flags_i,
  input logic [CSR_W-1:0]  csr_o,
  input logic              rnd_zero_o,
  input logic              flush_o,
  input logic              exc_req_o,
  input logic [CODE_W-1:0] exc_code_o
);
  assert_unimpl_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_o[CSR_W-1:IMPL_W] == '0);

  assert_write_stored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> csr_o == ($past(wr_data_i) & CSR_MASK));

  assert_rnd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_zero_o == (csr_o[RM_LSB +: RM_W] == RM_TO_ZERO));

  assert_flush_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o == csr_o[DN_BIT]);

  assert_cause_top_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(csr_o[CAUSE_LSB+CAUSE_W-1]));

  assert_req_after_op_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> $past(op_done_i && !wr_en_i && (op_flags_i != '0)));

  assert_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_code_o == (exc_req_o ? EXC_CODE : '0));

  assert_ordered_cmp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && op_cmp_i && !cmp_unord_i && !wr_en_i) |=> ($stable(csr_o) && !exc_req_o));

  assert_write_priority_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && op_done_i) |=> !exc_req_o);
endmodule

bind fp_status_ctrl fp_status_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .op_done_i   (op_done_i),
  .op_cmp_i    (op_cmp_i),
  .cmp_unord_i (cmp_unord_i),
  .op_flags_i  (op_flags_i),
  .csr_o       (csr_o),
  .rnd_zero_o  (rnd_zero_o),
  .flush_o     (flush_o),
  .exc_req_o   (exc_req_o),
  .exc_code_o  (exc_code_o)
);

// File: tb/fp_status_ctrl_test.sv
`timescale 1ns/1ps
module fp_status_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        op_done_i = 1'b0;
  logic        op_cmp_i = 1'b0;
  logic        cmp_unord_i = 1'b0;
  logic [4:0]  op_flags_i = '0;
  logic [31:0] csr_o;
  logic        rnd_zero_o, flush_o, exc_req_o;
  logic [11:0] exc_code_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_csr = '0;
  logic        exp_req = 1'b0;

  always #2 clk = ~clk;

  fp_status_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .op_done_i(op_done_i), .op_cmp_i(op_cmp_i), .cmp_unord_i(cmp_unord_i),
    .op_flags_i(op_flags_i), .csr_o(csr_o), .rnd_zero_o(rnd_zero_o),
    .flush_o(flush_o), .exc_req_o(exc_req_o), .exc_code_o(exc_code_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected next word and request after an accepted operation.
  task automatic model_op(input logic [4:0] f);
    logic [31:0] n;
    n = exp_csr;
    n[6:2] = f;
    if (f != 0) n[16:12] = n[16:12] | f;
    exp_req = (f != 0) && ((n[16:12] & exp_csr[11:7]) != 0);
    exp_csr = n;
  endtask

  task automatic check_state(input string req);
    check(req, csr_o, exp_csr);
    check(req, {31'd0, exc_req_o}, {31'd0, exp_req});
    check(req, {20'd0, exc_code_o}, exp_req ? 32'h120 : 32'h0);
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = 32'hDEAD_BEEF;
    exp_csr = d & 32'h0007_FFFF;
    exp_req = 1'b0;
  endtask

  task automatic do_op(input logic cmp, input logic unord, input logic [4:0] f);
    @(negedge clk);
    op_done_i = 1'b1; op_cmp_i = cmp; cmp_unord_i = unord; op_flags_i = f;
    @(negedge clk);
    op_done_i = 1'b0; op_cmp_i = 1'b0; cmp_unord_i = 1'b0; op_flags_i = 5'h1F;
    if (!cmp || unord) model_op(f);
    else exp_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] en_set [4];
    en_set[0] = 5'h00; en_set[1] = 5'h1F; en_set[2] = 5'h05; en_set[3] = 5'h12;
    op_flags_i = 5'h1F;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", csr_o, 32'h0);
    check("R1", {31'd0, exc_req_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", csr_o, 32'h0);

    // R2 masking
    do_write(32'hFFFF_FFFF);
    check_state("R2");
    do_write(32'hABCD_1234);
    check_state("R2");

    // R3/R4 decode sweep over rounding and denormal bits
    for (int rm = 0; rm < 4; rm++) begin
      for (int dn = 0; dn < 2; dn++) begin
        do_write(32'h0000_0F80 | (32'(dn) << 18) | 32'(rm));
        check("R3", {31'd0, rnd_zero_o}, {31'd0, rm == 1});
        check("R4", {31'd0, flush_o}, 32'(dn));
      end
    end

    // R5/R6/R7 sweep all flag patterns under several enable masks
    for (int e = 0; e < 4; e++) begin
      do_write((32'(en_set[e]) << 7) | 32'h0004_0002);
      for (int f = 0; f < 32; f++) begin
        do_op(1'b0, 1'b0, 5'(f));
        check_state("R5_R6_R7");
      end
      @(negedge clk);
      exp_req = 1'b0;
      check("R7 pulse width", {31'd0, exc_req_o}, 32'h0);
    end

    // R6 top cause bit kept, cleared only by write
    do_write(32'h0002_0000);
    do_op(1'b0, 1'b0, 5'h04);
    check_state("R6");
    do_op(1'b0, 1'b0, 5'h00);
    check_state("R6");

    // R7 enabled cause set earlier re-requests on any later flag
    do_write(32'h0000_0080);
    do_op(1'b0, 1'b0, 5'h01);
    check_state("R7");
    do_op(1'b0, 1'b0, 5'h10);
    check_state("R7");
    do_op(1'b0, 1'b0, 5'h00);
    check_state("R7 no flag");

    // R8 compares
    do_write(32'h0000_F800);
    do_op(1'b1, 1'b0, 5'h10);
    check_state("R8 ordered");
    do_op(1'b1, 1'b1, 5'h10);
    check_state("R8 unordered");
    do_op(1'b1, 1'b0, 5'h1F);
    check_state("R8 ordered after");

    // R9 write and op together
    @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = 32'h0000_0F81;
    op_done_i = 1'b1; op_flags_i = 5'h1F;
    @(negedge clk);
    wr_en_i = 1'b0; op_done_i = 1'b0;
    exp_csr = 32'h0000_0F81; exp_req = 1'b0;
    check_state("R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule